// File: doc/BRIEF.md
# Finite-Set Predictive Current Selector

Once per sampling period this block picks the gate command for a two-level inverter with four legs. It starts when `start_i` is pulsed. At that edge it captures three measured phase currents, three reference currents and a list of candidate switching states. It then predicts the next-sample phase currents for each candidate with a fixed discrete model, i(k+1) = G·i(k) + Q·v. The model matrices are precomputed, and v is the candidate's phase-to-neutral voltage vector. Each prediction gets a score, and the cheapest candidate is registered as the new gate command.

The score has two parts. The first is the sum of the absolute current errors of the three phases. The second is a fixed penalty that applies only when the candidate would toggle the neutral leg relative to the state now applied. The term G·i(k) is the same for every candidate, so it is formed once. The candidates are then scored one per clock, which puts the cost of a sweep in cycles rather than in multipliers. All arithmetic is signed fixed point. The currents carry `IFRAC` fractional bits and the coefficients carry `CFRAC`. The default penalty is half an ampere, 1 << (IFRAC-1).

Top module: `pcs_select`

## Requirements
- R1: While reset is held and after it is released, `gate_o` is 4'b0000 (all legs low) and `done_o` is low. The neutral bit that the penalty compares against therefore starts at 0.
- R2: A switching state is four bits: [3] = leg x, [2] = leg y, [1] = leg z, [0] = neutral leg n. Candidate k occupies `cand_i[4k+3:4k]`. Phase p (0 = x, 1 = y, 2 = z) of `meas_i` and `ref_i` occupies bits [16p+15:16p]. Matrix entry (r,c) of `g_i` and `q_i` occupies bits [16(3r+c)+15:16(3r+c)]. For each candidate the predicted current of phase r is (Σc G[r][c]·i[c] + Σc Q[r][c]·(S_c − S_n)·vdc) >>> CFRAC. The tracking part of the cost is Σr |ref[r] − pred[r]|.
- R3: The cost adds `SW_PEN` when the candidate's bit [0] differs from bit [0] of `gate_o` at the time of the start. Otherwise it adds nothing. The candidate with the smallest total cost becomes `gate_o`.
- R4: When two candidates have equal total cost, the one with the lower list index wins.
- R5: `gate_o` changes only on the edge that raises `done_o`. It holds its value in every other cycle.
- R6: If `start_i` is sampled high at edge E0 in the idle state and N candidates are to be evaluated, then `done_o` is high for exactly one cycle, the cycle following edge E(N+1).
- R7: While a sweep is in progress, `start_i` is ignored. Currents, references, the candidate list and the count are taken only at the start edge, so later changes to them do not affect the result.
- R8: A `cand_cnt_i` larger than `NC` is treated as `NC`. A count of 0 leaves `gate_o` unchanged and raises `done_o` after edge E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a sweep when idle |
| meas_i | input | 3*IW | Measured phase currents x, y, z (signed) |
| ref_i | input | 3*IW | Reference phase currents x, y, z (signed) |
| g_i | input | 9*CW | State matrix G, row major (signed, CFRAC fraction bits) |
| q_i | input | 9*CW | Input matrix Q, row major (signed, CFRAC fraction bits) |
| vdc_i | input | VW | DC-link voltage (unsigned) |
| cand_i | input | 4*NC | Candidate switching states |
| cand_cnt_i | input | CNW | Number of valid candidates |
| gate_o | output | 4 | Applied switching state |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The hardest situation to create is one where the neutral-leg penalty actually changes the winner. That needs a candidate that tracks the reference better yet loses because it toggles the neutral leg, and it only arises when the tracking advantage is smaller than `SW_PEN`. The bench reaches it with a diagonal Q, a zero G and a small DC-link voltage. With those settings each phase prediction is exactly ±vdc or 0, so the references can be placed so that the tracking gap falls just below or just above the penalty. Exact ties come from zero matrices, and a second start pulse injected partway through a sweep shows that the pulse is ignored.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EVAL = 2'd2
    } phase_e;

    localparam int LEG_X = 3;
    localparam int LEG_Y = 2;
    localparam int LEG_Z = 1;
    localparam int LEG_N = 0;
endpackage

// File: rtl/pcs_gi_mac.sv
module pcs_gi_mac #(
    parameter int IW = 16,
    parameter int CW = 16,
    parameter int AW = 36
) (
    input  logic [2:0][IW-1:0] cur_i,
    input  logic [8:0][CW-1:0] g_i,
    output logic [2:0][AW-1:0] acc_o
);
    for (genvar r = 0; r < 3; r++) begin : g_row
        always_comb begin
            logic signed [AW-1:0] sum;
            sum = '0;
            for (int c = 0; c < 3; c++) begin
                sum = sum + AW'($signed(g_i[r*3+c]) * $signed(cur_i[c]));
            end
            acc_o[r] = sum;
        end
    end
endmodule

// File: rtl/pcs_cand_cost.sv
module pcs_cand_cost #(
    parameter int IW    = 16,
    parameter int CW    = 16,
    parameter int VW    = 16,
    parameter int AW    = 36,
    parameter int CSTW  = 40,
    parameter int CFRAC = 12,
    parameter logic [CSTW-1:0] SW_PEN = CSTW'(128)
) (
    input  logic [2:0][AW-1:0] gi_i,
    input  logic [8:0][CW-1:0] q_i,
    input  logic [VW-1:0]      vdc_i,
    input  logic [2:0][IW-1:0] ref_i,
    input  logic [3:0]         cand_i,
    input  logic               prev_n_i,
    output logic [CSTW-1:0]    cost_o
);
    import pcs_pkg::*;

    localparam int PW = CW + VW + 1;

    logic [2:0] leg_bit;
    assign leg_bit = {cand_i[LEG_Z], cand_i[LEG_Y], cand_i[LEG_X]};

    logic [2:0][AW:0] mag;

    for (genvar r = 0; r < 3; r++) begin : g_phase
        always_comb begin
            logic signed [AW-1:0] acc;
            logic signed [AW-1:0] pred;
            logic signed [PW-1:0] prod;
            logic signed [AW:0]   err;
            acc = $signed(gi_i[r]);
            for (int c = 0; c < 3; c++) begin
                prod = $signed(q_i[r*3+c]) * $signed({1'b0, vdc_i});
                if (leg_bit[c] && !cand_i[LEG_N]) begin
                    acc = acc + AW'(prod);
                end else if (!leg_bit[c] && cand_i[LEG_N]) begin
                    acc = acc - AW'(prod);
                end
            end
            pred = acc >>> CFRAC;
            err  = (AW+1)'($signed(ref_i[r])) - (AW+1)'(pred);
            mag[r] = err[AW] ? -err : err;
        end
    end

    always_comb begin
        cost_o = CSTW'(mag[0]) + CSTW'(mag[1]) + CSTW'(mag[2]);
        if (cand_i[LEG_N] != prev_n_i) begin
            cost_o = cost_o + SW_PEN;
        end
    end
endmodule

// File: rtl/pcs_select.sv
module pcs_select #(
    parameter int IW    = 16,
    parameter int CW    = 16,
    parameter int VW    = 16,
    parameter int NC    = 7,
    parameter int IFRAC = 8,
    parameter int CFRAC = 12,
    parameter int CNW   = $clog2(NC + 1) + 1,
    parameter int SW_PEN = 1 << (IFRAC - 1)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              start_i,
    input  logic [3*IW-1:0]   meas_i,
    input  logic [3*IW-1:0]   ref_i,
    input  logic [9*CW-1:0]   g_i,
    input  logic [9*CW-1:0]   q_i,
    input  logic [VW-1:0]     vdc_i,
    input  logic [4*NC-1:0]   cand_i,
    input  logic [CNW-1:0]    cand_cnt_i,
    output logic [3:0]        gate_o,
    output logic              done_o
);
    import pcs_pkg::*;

    localparam int CIW  = (NC > 1) ? $clog2(NC) : 1;
    localparam int MW   = ((IW > VW + 1) ? IW : VW + 1);
    localparam int AW   = MW + CW + 3;
    localparam int CSTW = AW + 4;
    localparam logic [CNW-1:0] NC_CNT = CNW'(NC);

    typedef struct packed {
        phase_e               phase;
        logic [CIW-1:0]       idx;
        logic [CNW-1:0]       cnt;
        logic [2:0][IW-1:0]   cur;
        logic [2:0][IW-1:0]   rf;
        logic [NC-1:0][3:0]   cand;
        logic [2:0][AW-1:0]   gi;
        logic [CSTW-1:0]      best_cost;
        logic [3:0]           best_st;
        logic [3:0]           gate;
        logic                 done;
    } st_t;

    st_t st_d, st_q;

    logic [2:0][AW-1:0] gi_w;
    logic [CSTW-1:0]    cost_w;
    logic [3:0]         cur_cand;

    assign cur_cand = st_q.cand[st_q.idx];

    pcs_gi_mac #(
        .IW (IW),
        .CW (CW),
        .AW (AW)
    ) u_gi (
        .cur_i (st_q.cur),
        .g_i   (g_i),
        .acc_o (gi_w)
    );

    pcs_cand_cost #(
        .IW    (IW),
        .CW    (CW),
        .VW    (VW),
        .AW    (AW),
        .CSTW  (CSTW),
        .CFRAC (CFRAC),
        .SW_PEN(CSTW'(SW_PEN))
    ) u_cost (
        .gi_i     (st_q.gi),
        .q_i      (q_i),
        .vdc_i    (vdc_i),
        .ref_i    (st_q.rf),
        .cand_i   (cur_cand),
        .prev_n_i (st_q.gate[LEG_N]),
        .cost_o   (cost_w)
    );

    always_comb begin
        logic take;
        st_d      = st_q;
        st_d.done = 1'b0;
        take      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_PRE;
                    st_d.cur   = meas_i;
                    st_d.rf    = ref_i;
                    st_d.cand  = cand_i;
                    st_d.idx   = '0;
                    st_d.cnt   = (cand_cnt_i > NC_CNT) ? NC_CNT : cand_cnt_i;
                end
            end
            PH_PRE: begin
                st_d.gi = gi_w;
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.phase = PH_EVAL;
                end
            end
            PH_EVAL: begin
                take = (st_q.idx == '0) || (cost_w < st_q.best_cost);
                if (take) begin
                    st_d.best_cost = cost_w;
                    st_d.best_st   = cur_cand;
                end
                if (CNW'(st_q.idx) == st_q.cnt - CNW'(1)) begin
                    st_d.gate  = take ? cur_cand : st_q.best_st;
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.idx = st_q.idx + CIW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
    assign done_o = st_q.done;

    logic [1:0]     phase_w;
    logic [CIW-1:0] idx_w;
    logic [CNW-1:0] cnt_w;
    assign phase_w = st_q.phase;
    assign idx_w   = st_q.idx;
    assign cnt_w   = st_q.cnt;
endmodule

// File: rtl/pcs_select_chk.sv
module pcs_select_chk #(
    parameter int NC  = 7,
    parameter int CIW = 3,
    parameter int CNW = 4
) (
    input logic           clk_i,
    input logic           rst_n_i,
    input logic           done_i,
    input logic [3:0]     gate_i,
    input logic [1:0]     phase_i,
    input logic [CIW-1:0] idx_i,
    input logic [CNW-1:0] cnt_i
);
    AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$past(rst_n_i) |-> (gate_i == 4'b0000 && !done_i)); // R1
    AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !done_i |-> $stable(gate_i)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_i |=> !done_i); // R6
    AST_DONE_FROM_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_i |-> ($past(phase_i) == 2'd1 || $past(phase_i) == 2'd2)); // R7
    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (phase_i == 2'd2) |-> (CNW'(idx_i) < cnt_i)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_i <= CNW'(NC)); // R8
endmodule

bind pcs_select pcs_select_chk #(
    .NC  (NC),
    .CIW (CIW),
    .CNW (CNW)
) u_chk (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .done_i  (done_o),
    .gate_i  (gate_o),
    .phase_i (phase_w),
    .idx_i   (idx_w),
    .cnt_i   (cnt_w)
);

// File: tb/pcs_select_bench.sv
`timescale 1ns/1ps
module pcs_select_bench;
    localparam int NC = 7;
    localparam int CNW = 4;
    localparam int CFRAC = 12;
    localparam longint PEN = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] cur_b [3];
    logic signed [15:0] ref_b [3];
    logic signed [15:0] g_b [9];
    logic signed [15:0] q_b [9];
    logic [15:0] vdc;
    logic [3:0] cand_b [NC];
    logic [CNW-1:0] cnt;
    logic [47:0] meas_w, ref_w;
    logic [143:0] g_w, q_w;
    logic [4*NC-1:0] cand_w;
    logic [3:0] gate;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] mdl_gate = 4'b0000;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < 3; p++) begin
            meas_w[p*16 +: 16] = cur_b[p];
            ref_w[p*16 +: 16]  = ref_b[p];
        end
        for (int e = 0; e < 9; e++) begin
            g_w[e*16 +: 16] = g_b[e];
            q_w[e*16 +: 16] = q_b[e];
        end
        for (int k = 0; k < NC; k++) cand_w[k*4 +: 4] = cand_b[k];
    end

    pcs_select u_pcs_select (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start),
        .meas_i(meas_w), .ref_i(ref_w), .g_i(g_w), .q_i(q_w),
        .vdc_i(vdc), .cand_i(cand_w), .cand_cnt_i(cnt),
        .gate_o(gate), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint cost_of(input logic [3:0] s, input logic pn);
        longint tot = 0;
        for (int r = 0; r < 3; r++) begin
            longint acc = 0;
            for (int c = 0; c < 3; c++) begin
                longint v = longint'(s[3-c]) - longint'(s[0]);
                acc += longint'(g_b[r*3+c]) * longint'(cur_b[c]);
                acc += longint'(q_b[r*3+c]) * v * longint'(vdc);
            end
            acc = acc >>> CFRAC;
            tot += (longint'(ref_b[r]) > acc) ? longint'(ref_b[r]) - acc : acc - longint'(ref_b[r]);
        end
        if (s[0] != pn) tot += PEN;
        return tot;
    endfunction

    task automatic run(input int c_in, input bit mid, input string req);
        int eff;
        int k;
        longint best;
        logic [3:0] exp_g;
        eff = (c_in > NC) ? NC : c_in;
        exp_g = mdl_gate;
        best = 0;
        for (int i = 0; i < eff; i++) begin
            longint cc = cost_of(cand_b[i], mdl_gate[0]);
            if (i == 0 || cc < best) begin best = cc; exp_g = cand_b[i]; end
        end
        @(negedge clk);
        start = 1'b1;
        cnt = CNW'(c_in);
        @(negedge clk);
        start = 1'b0;
        k = 1;
        if (mid) begin
            for (int p = 0; p < 3; p++) begin cur_b[p] = -cur_b[p]; ref_b[p] = ref_b[p] + 16'sd300; end
            for (int i = 0; i < NC; i++) cand_b[i] = ~cand_b[i];
            cnt = 4'd1;
        end
        while (!done && k < 60) begin
            @(negedge clk);
            k++;
            if (mid && k == 2) start = 1'b1;
            else start = 1'b0;
            if (!done) check(gate == mdl_gate, "R5", gate, mdl_gate);
        end
        start = 1'b0;
        check(k == eff + 2, "R6", k, eff + 2);
        check(gate == exp_g, req, gate, exp_g);
        mdl_gate = exp_g;
        @(negedge clk);
        check(!done, "R6", done, 0);
        if (mid) begin
            for (int i = 0; i < eff + 4; i++) begin
                @(negedge clk);
                check(!done && gate == exp_g, "R7", {done, gate}, exp_g);
            end
        end
    endtask

    task automatic zero_model();
        for (int e = 0; e < 9; e++) begin g_b[e] = '0; q_b[e] = '0; end
        for (int p = 0; p < 3; p++) begin cur_b[p] = '0; ref_b[p] = '0; end
    endtask

    task automatic randomize_inputs();
        for (int e = 0; e < 9; e++) begin
            g_b[e] = 16'(int'($urandom_range(8192)) - 4096);
            q_b[e] = 16'(int'($urandom_range(256)) - 128);
        end
        for (int p = 0; p < 3; p++) begin
            cur_b[p] = 16'(int'($urandom_range(20000)) - 10000);
            ref_b[p] = 16'(int'($urandom_range(20000)) - 10000);
        end
        vdc = 16'($urandom_range(400));
        for (int i = 0; i < NC; i++) cand_b[i] = 4'($urandom_range(15));
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        zero_model();
        vdc = '0;
        cnt = '0;
        for (int i = 0; i < NC; i++) cand_b[i] = '0;
        repeat (4) @(negedge clk);
        check(gate == 4'b0000 && !done, "R1", {done, gate}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gate == 4'b0000 && !done, "R1", {done, gate}, 0);

        // R4: all costs equal except penalty; two candidates tie, earlier wins
        zero_model();
        cand_b[0] = 4'b1000; cand_b[1] = 4'b0100; cand_b[2] = 4'b0011;
        run(3, 1'b0, "R4");
        check(gate == 4'b1000, "R4", gate, 4'b1000);

        // R3: penalty alone picks the non-toggling state
        cand_b[0] = 4'b0001; cand_b[1] = 4'b0010;
        run(2, 1'b0, "R3");
        check(gate == 4'b0010, "R3", gate, 4'b0010);

        // R3: penalty outweighs a smaller tracking gain
        zero_model();
        for (int p = 0; p < 3; p++) q_b[p*3+p] = 16'sd4096;
        vdc = 16'd100;
        for (int p = 0; p < 3; p++) ref_b[p] = -16'sd60;
        cand_b[0] = 4'b0000; cand_b[1] = 4'b0001;
        run(2, 1'b0, "R3");
        check(gate == 4'b0000, "R3", gate, 4'b0000);
        // R3: larger tracking gain overcomes the penalty
        for (int p = 0; p < 3; p++) ref_b[p] = -16'sd100;
        run(2, 1'b0, "R3");
        check(gate == 4'b0001, "R3", gate, 4'b0001);

        // R8: count 0 keeps the gate, count above NC clamps
        run(0, 1'b0, "R8");
        for (int i = 0; i < NC; i++) cand_b[i] = 4'b0001;
        cand_b[NC-1] = 4'b0111;
        for (int p = 0; p < 3; p++) ref_b[p] = 16'sd0;
        ref_b[0] = -16'sd100;
        run(15, 1'b0, "R8");

        // R7: second start and input changes mid sweep are ignored
        randomize_inputs();
        run(NC, 1'b1, "R7");

        // R2: sweep of every single state as sole candidate, and random lists
        for (int s = 0; s < 16; s++) begin
            randomize_inputs();
            cand_b[0] = 4'(s);
            run(1, 1'b0, "R2");
        end
        for (int t = 0; t < 300; t++) begin
            randomize_inputs();
            run(int'($urandom_range(NC)) + 1, 1'b0, "R2");
        end
        for (int t = 0; t < 60; t++) begin
            randomize_inputs();
            vdc = 16'd0;
            for (int e = 0; e < 9; e++) g_b[e] = 16'sd0;
            run(NC, 1'b0, "R4");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule